// File: doc/BRIEF.md
# Averaged Read Strobe Trainer

This engine trains the receive strobe delay of eight byte lanes at once. It does not touch memory. An external tester writes a 40-word pattern and reads it back at the delays the engine drives. It compares each lane's byte against the lowest byte of the expected word and returns one error bit per lane. The engine asks for one test at a time with a request/response handshake and moves the per-lane delays between tests.

A lane's delay is a fine phase (0 to 7) nested inside a coarse tap (0 to 14). Each of three loops starts every lane at zero. The first search steps lanes forward until the whole error mask reads clean, and each lane's count is its lower edge. The second search carries on from there until the whole mask reads failing, which gives the upper edge. Lanes never move independently of the test: a round always tests all lanes together, and only lanes that do not yet show the sought result move. The per-lane centers of the three loops are summed, and their average becomes the final delay, given as a step count.

Top module: `strobe_avg_trainer`

## Requirements
- R1: Out of reset, test_req_o, done_o and fail_o are low and every lane's phase and tap fields are zero.
- R2: A lane's delay is a step count s. Lane l shows phase s mod 8 on dly_phase_o[3l+2:3l] and tap s/8 on dly_tap_o[4l+3:4l]. The highest legal setting is tap 14, phase 7 (s = 119).
- R3: At the first test of each loop, every lane's delay is step zero.
- R4: A response counts only while test_req_o is high, and it is taken on the cycle test_ack_i is high. In the passing search, each accepted response with err_mask_i non-zero moves every lane whose bit is 1 one step up and adds one to its lower count. The search ends on the first all-zero mask, so it takes (largest first-passing step + 1) tests.
- R5: The failing search starts from the delays the passing search reached, with upper count equal to lower count. Each accepted response that is not all ones moves every lane whose bit is 0 one step up and adds one to its upper count. An all-ones mask ends the search.
- R6: A step requested at s = 119 during the passing search is fatal. fail_o rises on the next cycle and test_req_o drops.
- R7: A step requested at s = 119 during the failing search still adds one to the upper count. The delay stays at 119, and the search ends after that response.
- R8: Each loop adds floor((lower + upper) / 2) to a per-lane sum. After three loops, result_o lane l (bits [7l+6:7l]) holds floor(sum / 3), and done_o is high.
- R9: While done_o is high, each lane's phase and tap show its result step count.
- R10: start_i is ignored while a search is in progress. From idle, done or fail, start_i clears all sums and counts and begins loop one.
- R11: While test_req_o is high and no response arrives, the delay outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a full three-loop training |
| test_req_o | output | 1 | A test at the present delays is wanted |
| test_ack_i | input | 1 | Test result is valid on err_mask_i |
| err_mask_i | input | 8 | Per-lane error bits, 1 = lane failed |
| dly_phase_o | output | 24 | Per-lane phase, 3 bits per lane |
| dly_tap_o | output | 32 | Per-lane tap, 4 bits per lane |
| result_o | output | 56 | Per-lane averaged step count, 7 bits per lane |
| done_o | output | 1 | Training finished, result valid |
| fail_o | output | 1 | Passing search overflowed |

## Verification
A stuck or mis-stepping delay counter shows at once on the phase and tap outputs of the next test request, because the tester's pass window is keyed to the exact step. A wrong lower or upper count shows only at the end, as a result off by about half an edge. A mistake in the search-end rules shows as a wrong number of tests per search, which the bench counts. An overflow handled wrongly either raises fail_o where none was due or shifts the average by a step.

// File: rtl/strobe_trn_pkg.sv
package strobe_trn_pkg;
  typedef enum logic [2:0] {
    OP_NONE, OP_START, OP_STEP_LO, OP_TO_HI, OP_STEP_HI, OP_ACCUM, OP_FINAL
  } lane_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LO, ST_HI, ST_ACC, ST_FIN, ST_DONE, ST_FAIL
  } trn_state_e;
endpackage

// File: rtl/strobe_trn_lane.sv
module strobe_trn_lane
  import strobe_trn_pkg::*;
#(
  parameter int NSTEPS = 120,
  parameter int STEP_W = 7,
  parameter int CNT_W  = 8,
  parameter int ACC_W  = 9,
  parameter int LOOPS  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  lane_op_e          op_i,
  input  logic              err_i,
  output logic              ovf_o,
  output logic [STEP_W-1:0] dly_o,
  output logic [STEP_W-1:0] res_o
);
  logic [STEP_W-1:0] dly_q;
  logic [CNT_W-1:0]  lo_q, hi_q;
  logic [ACC_W-1:0]  acc_q;
  logic              want, at_max;

  // lane moves when its bit differs from the result being sought
  assign want   = (op_i == OP_STEP_LO && err_i) || (op_i == OP_STEP_HI && !err_i);
  assign at_max = (dly_q == STEP_W'(NSTEPS - 1));
  assign ovf_o  = want && at_max;
  assign dly_o  = dly_q;
  assign res_o  = STEP_W'(acc_q / ACC_W'(LOOPS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
      acc_q <= '0;
    end else begin
      unique case (op_i)
        OP_START: begin
          dly_q <= '0;
          lo_q  <= '0;
          hi_q  <= '0;
          acc_q <= '0;
        end
        OP_STEP_LO: if (want) begin
          lo_q <= lo_q + 1'b1;
          if (!at_max) dly_q <= dly_q + 1'b1;
        end
        OP_TO_HI: hi_q <= lo_q;
        OP_STEP_HI: if (want) begin
          hi_q <= hi_q + 1'b1;
          if (!at_max) dly_q <= dly_q + 1'b1;
        end
        OP_ACCUM: begin
          acc_q <= acc_q + ACC_W'(({1'b0, lo_q} + {1'b0, hi_q}) >> 1);
          dly_q <= '0;
          lo_q  <= '0;
          hi_q  <= '0;
        end
        OP_FINAL: dly_q <= res_o;
        default: ;
      endcase
    end
  end

  assert_sat_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> $stable(dly_q));
  assert_loop_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_START || op_i == OP_ACCUM) |=> (dly_q == '0 && lo_q == '0));
  assert_hi_ge_lo_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_STEP_HI) |=> (hi_q >= lo_q));
  assert_final_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_FINAL) |=> (dly_q < STEP_W'(NSTEPS)));
endmodule

// File: rtl/strobe_trn_ctrl.sv
module strobe_trn_ctrl
  import strobe_trn_pkg::*;
#(
  parameter int NL    = 8,
  parameter int LOOPS = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          ack_i,
  input  logic [NL-1:0] mask_i,
  input  logic          any_ovf_i,
  output lane_op_e      op_o,
  output logic          req_o,
  output logic          done_o,
  output logic          fail_o
);
  localparam int LOOP_W = $clog2(LOOPS + 1);

  trn_state_e        st_q, st_d;
  logic [LOOP_W-1:0] loop_q, loop_d;

  always_comb begin
    op_o   = OP_NONE;
    st_d   = st_q;
    loop_d = loop_q;
    unique case (st_q)
      ST_IDLE, ST_DONE, ST_FAIL: if (start_i) begin
        op_o   = OP_START;
        st_d   = ST_LO;
        loop_d = '0;
      end
      ST_LO: if (ack_i) begin
        if (mask_i == '0) begin
          op_o = OP_TO_HI;
          st_d = ST_HI;
        end else begin
          op_o = OP_STEP_LO;
          if (any_ovf_i) st_d = ST_FAIL;
        end
      end
      ST_HI: if (ack_i) begin
        if (mask_i == '1) begin
          st_d = ST_ACC;
        end else begin
          op_o = OP_STEP_HI;
          if (any_ovf_i) st_d = ST_ACC;
        end
      end
      ST_ACC: begin
        op_o = OP_ACCUM;
        if (loop_q == LOOP_W'(LOOPS - 1)) begin
          st_d = ST_FIN;
        end else begin
          loop_d = loop_q + 1'b1;
          st_d   = ST_LO;
        end
      end
      ST_FIN: begin
        op_o = OP_FINAL;
        st_d = ST_DONE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      loop_q <= '0;
    end else begin
      st_q   <= st_d;
      loop_q <= loop_d;
    end
  end

  assign req_o  = (st_q == ST_LO) || (st_q == ST_HI);
  assign done_o = (st_q == ST_DONE);
  assign fail_o = (st_q == ST_FAIL);

  assert_pass_end_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LO && ack_i && mask_i == '0) |=> (req_o && st_q == ST_HI));
  assert_fatal_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LO && ack_i && any_ovf_i) |=> (fail_o && !req_o));
  assert_busy_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i && start_i) |=> (req_o && $stable(loop_q)));
  assert_excl_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fail_o) && !(req_o && (done_o || fail_o)));
endmodule

// File: rtl/strobe_avg_trainer.sv
module strobe_avg_trainer
  import strobe_trn_pkg::*;
#(
  parameter int NUM_LANES = 8,
  parameter int PHASE_MAX = 7,
  parameter int TAP_MAX   = 14,
  parameter int NUM_LOOPS = 3,
  localparam int NPH      = PHASE_MAX + 1,
  localparam int NSTEPS   = NPH * (TAP_MAX + 1),
  localparam int STEP_W   = $clog2(NSTEPS),
  localparam int PH_W     = $clog2(NPH),
  localparam int TAP_W    = $clog2(TAP_MAX + 1),
  localparam int CNT_W    = $clog2(2 * NSTEPS + 1),
  localparam int ACC_W    = $clog2(NUM_LOOPS * NSTEPS + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  output logic                        test_req_o,
  input  logic                        test_ack_i,
  input  logic [NUM_LANES-1:0]        err_mask_i,
  output logic [NUM_LANES*PH_W-1:0]   dly_phase_o,
  output logic [NUM_LANES*TAP_W-1:0]  dly_tap_o,
  output logic [NUM_LANES*STEP_W-1:0] result_o,
  output logic                        done_o,
  output logic                        fail_o
);
  lane_op_e             lane_op;
  logic [NUM_LANES-1:0] ovf;

  strobe_trn_ctrl #(.NL(NUM_LANES), .LOOPS(NUM_LOOPS)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .ack_i     (test_ack_i),
    .mask_i    (err_mask_i),
    .any_ovf_i (|ovf),
    .op_o      (lane_op),
    .req_o     (test_req_o),
    .done_o    (done_o),
    .fail_o    (fail_o)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic [STEP_W-1:0] dly;
    logic [STEP_W-1:0] res;

    strobe_trn_lane #(
      .NSTEPS(NSTEPS), .STEP_W(STEP_W), .CNT_W(CNT_W), .ACC_W(ACC_W), .LOOPS(NUM_LOOPS)
    ) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .op_i   (lane_op),
      .err_i  (err_mask_i[g]),
      .ovf_o  (ovf[g]),
      .dly_o  (dly),
      .res_o  (res)
    );

    assign dly_phase_o[g*PH_W +: PH_W]  = PH_W'(dly % STEP_W'(NPH));
    assign dly_tap_o[g*TAP_W +: TAP_W]  = TAP_W'(dly / STEP_W'(NPH));
    assign result_o[g*STEP_W +: STEP_W] = res;
  end

  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_req_o && !test_ack_i) |=> ($stable(dly_phase_o) && $stable(dly_tap_o)));
endmodule

// File: tb/sim_strobe_avg_trainer.sv
module sim_strobe_avg_trainer;
  localparam int NL = 8;
  localparam int NPH = 8;
  localparam int NSTEPS = 120;
  localparam int LOOPS = 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, ack = 1'b0;
  logic [NL-1:0] mask = '0;
  logic req, done, fail;
  logic [NL*3-1:0] dly_phase;
  logic [NL*4-1:0] dly_tap;
  logic [NL*7-1:0] result;

  int nchk = 0, nfail = 0, cyc = 0;

  strobe_avg_trainer u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .test_req_o(req), .test_ack_i(ack),
    .err_mask_i(mask), .dly_phase_o(dly_phase), .dly_tap_o(dly_tap), .result_o(result),
    .done_o(done), .fail_o(fail)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  function automatic int win_a(int cs, int lp, int ln);
    if (cs == 7 && ln == 3) return 500;
    return (ln * 7 + lp * 5 + cs * 11) % 50;
  endfunction

  function automatic int win_b(int cs, int lp, int ln);
    if (cs == 6 && ln == 0) return 200;
    return win_a(cs, lp, ln) + 8 + ((ln * 13 + lp * 3 + cs * 5) % 40);
  endfunction

  function automatic int lane_s(int ln);
    return int'(dly_tap[ln*4 +: 4]) * NPH + int'(dly_phase[ln*3 +: 3]);
  endfunction

  task automatic run_case(input int cs);
    int lp, ph, first, pr, fr, bad_st, ovf_rnd, exp_r, mx, up, a, b, bad;
    int s[NL];
    int esum[NL];
    logic [NL-1:0] m;
    for (int ln = 0; ln < NL; ln++) begin
      esum[ln] = 0;
      for (int l2 = 0; l2 < LOOPS; l2++) begin
        a = win_a(cs, l2, ln);
        b = win_b(cs, l2, ln);
        up = (b >= NSTEPS - 1) ? NSTEPS : b + 1;
        esum[ln] += (a + up) / 2;
      end
    end
    lp = 0; ph = 0; first = 1; pr = 0; fr = 0; bad_st = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!(done || fail)) begin
      if (!req) begin
        @(negedge clk);
        continue;
      end
      ovf_rnd = 0;
      for (int ln = 0; ln < NL; ln++) begin
        s[ln] = lane_s(ln);
        m[ln] = (s[ln] < win_a(cs, lp, ln)) || (s[ln] > win_b(cs, lp, ln));
        if (ph == 1 && !m[ln] && s[ln] == NSTEPS - 1) ovf_rnd = 1;
      end
      if (first) begin
        bad = 0;
        for (int ln = 0; ln < NL; ln++)
          if (s[ln] != ((ph == 0) ? 0 : win_a(cs, lp, ln))) bad++;
        if (ph == 0) chk(bad == 0, "R3 loop starts at zero", bad, 0);
        else         chk(bad == 0, "R5 fail search continues", bad, 0);
        first = 0;
      end
      if (cs == 1 && lp == 1 && ph == 1 && fr == 0) begin
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        bad = 0;
        for (int ln = 0; ln < NL; ln++) if (lane_s(ln) != s[ln]) bad++;
        chk(req && bad == 0, "R10 start ignored while busy", bad, 0);
      end
      if ((pr + fr) % 3 == 0) begin
        @(negedge clk);
        for (int ln = 0; ln < NL; ln++) if (lane_s(ln) != s[ln]) bad_st++;
      end
      mask = m; ack = 1'b1;
      @(negedge clk); ack = 1'b0;
      if (ph == 0) begin
        pr++;
        if (m == '0) begin
          mx = 0;
          for (int ln = 0; ln < NL; ln++) if (win_a(cs, lp, ln) > mx) mx = win_a(cs, lp, ln);
          chk(pr == mx + 1, "R4 pass search length", pr, mx + 1);
          ph = 1; first = 1; fr = 0;
        end
      end else begin
        fr++;
        if (m == '1 || ovf_rnd) begin
          mx = 0; exp_r = NSTEPS * 4;
          for (int ln = 0; ln < NL; ln++) begin
            a = win_a(cs, lp, ln); b = win_b(cs, lp, ln);
            if (b >= NSTEPS - 1) begin
              if (NSTEPS - a < exp_r) exp_r = NSTEPS - a;
            end else if (b + 1 - a > mx) mx = b + 1 - a;
          end
          if (exp_r == NSTEPS * 4) exp_r = mx + 1;
          chk(fr == exp_r, "R5 fail search length", fr, exp_r);
          if (ovf_rnd) chk(lane_s(0) == NSTEPS - 1, "R7 delay saturates", lane_s(0), NSTEPS - 1);
          lp++; ph = 0; first = 1; pr = 0;
        end
      end
    end
    chk(bad_st == 0, "R11 delays held while waiting", bad_st, 0);
    if (cs == 7) begin
      chk(fail && !done && !req, "R6 fatal pass overflow", int'(fail), 1);
      chk(pr == NSTEPS, "R6 tests before fatal", pr, NSTEPS);
    end else begin
      chk(done && !fail, "R8 done raised", int'(done), 1);
      for (int ln = 0; ln < NL; ln++) begin
        chk(int'(result[ln*7 +: 7]) == esum[ln] / LOOPS, "R8 averaged result",
            int'(result[ln*7 +: 7]), esum[ln] / LOOPS);
        chk(lane_s(ln) == esum[ln] / LOOPS, "R9 final delay shown", lane_s(ln), esum[ln] / LOOPS);
        chk(int'(dly_phase[ln*3 +: 3]) == (esum[ln] / LOOPS) % NPH, "R2 phase field",
            int'(dly_phase[ln*3 +: 3]), (esum[ln] / LOOPS) % NPH);
      end
      repeat (3) @(negedge clk);
      chk(!req && done, "R10 idle after done", int'(req), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!req && !done && !fail, "R1 reset outputs", int'({req, done, fail}), 0);
    chk(dly_phase == '0 && dly_tap == '0, "R1 reset delays", int'(dly_tap), 0);
    for (int cs = 0; cs < 9; cs++) run_case(cs);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule